// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Flags and Interrupt

The block holds two byte-wide FIFOs between a register bus and a serial engine. The transmit queue is filled by bus writes and drained by the engine. The receive queue is filled by the engine and drained by bus reads. Each queue reports level flags that follow its fill count. Each queue also has a sticky overrun flag, which is set when a push is attempted on a full queue and is cleared only by software. A mask register selects which flags drive a single registered interrupt line.

Software programs a nearly-empty threshold for the transmit queue, a nearly-full threshold for the receive queue, and the interrupt mask. It writes these through a small configuration port. Each queue also has a flush request. A flush empties that queue at once and leaves all configuration untouched. The flush then holds a busy indication for a fixed number of cycles, and the hardware drops it by itself.

Top module: `fifo_irq_top`

## Requirements
- R1: After reset both counts are 0, raw_o is 8'h33, masked_o is 0, irq_o is 0, both flush busy outputs are 0, and the mask and both thresholds are 0.
- R2: Each queue returns bytes in push order, and the oldest byte is shown on its read-data output. The count rises by one on an accepted push and falls by one on an accepted pop. A push and a pop in the same cycle leave the count unchanged. A pop on an empty queue is ignored.
- R3: A push while the queue holds DEPTH entries is discarded, even if a pop arrives in the same cycle, and the stored bytes stay as they were. The push sets the sticky overrun flag: raw bit 3 for transmit, raw bit 7 for receive. The flag stays set until a 1 is written to the same bit of clr_i. If a set and a clear arrive in the same cycle, the set wins.
- R4: Raw bit 0 is transmit empty (count 0), bit 2 is transmit full (count DEPTH), bit 4 is receive empty and bit 6 is receive full. These bits follow the count in the cycle after the push or pop that changes it.
- R5: Raw bit 1, transmit nearly-empty, is 1 exactly when the transmit count is less than or equal to the transmit threshold.
- R6: Raw bit 5, receive nearly-full, is 1 exactly when the receive count is greater than or equal to the receive threshold.
- R7: masked_o equals raw_o ANDed bit by bit with the mask. irq_o is the OR of masked_o, registered, so it lags masked_o by one cycle.
- R8: A one-cycle flush request empties the queue at the next edge. The busy output then reads 1 for FLUSH_CYCLES cycles and clears by itself. The mask and the thresholds are not changed by a flush. A request while busy is ignored.
- R9: While a queue's flush is busy, pushes and pops on that queue are ignored, and no overrun is flagged.
- R10: Writing 1 to clr_i bits other than 3 and 7 has no effect on any flag.
- R11: When cfg_we_i is high, cfg_sel_i picks the target: 0 for the mask (all 8 bits), 1 for the transmit threshold and 2 for the receive threshold (low CNT_W bits each). The value 3 writes nothing. A write takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Bus push into transmit queue |
| tx_wdata_i | input | DATA_W | Byte to push into transmit queue |
| tx_rd_i | input | 1 | Engine pop from transmit queue |
| tx_rdata_o | output | DATA_W | Oldest transmit byte |
| rx_wr_i | input | 1 | Engine push into receive queue |
| rx_wdata_i | input | DATA_W | Byte to push into receive queue |
| rx_rd_i | input | 1 | Bus pop from receive queue |
| rx_rdata_o | output | DATA_W | Oldest receive byte |
| tx_count_o | output | CNT_W | Transmit fill count |
| rx_count_o | output | CNT_W | Receive fill count |
| tx_flush_i | input | 1 | Transmit flush request pulse |
| rx_flush_i | input | 1 | Receive flush request pulse |
| tx_flush_o | output | 1 | Transmit flush busy |
| rx_flush_o | output | 1 | Receive flush busy |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_wdata_i | input | 8 | Configuration write value |
| clr_i | input | 8 | Write-one-to-clear for sticky flags |
| raw_o | output | 8 | Raw status flags |
| masked_o | output | 8 | Raw flags ANDed with mask |
| irq_o | output | 1 | Registered interrupt |

## Verification
Counts, level flags, masked bits, overrun flags and configuration changes all become visible one edge after the stimulus that causes them. irq_o appears one edge later than that. The bench drives its inputs just after a falling edge. It samples one falling edge later for first-order results, and two falling edges later for irq_o. Flush busy is sampled on each of the FLUSH_CYCLES falling edges that follow the request. It is then sampled once more, where it must be low, while a push held on the queue shows that nothing gets in.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned NFLAG   = 8;
  localparam int unsigned F_TXE   = 0;
  localparam int unsigned F_TXNE  = 1;
  localparam int unsigned F_TXF   = 2;
  localparam int unsigned F_TXOV  = 3;
  localparam int unsigned F_RXE   = 4;
  localparam int unsigned F_RXNF  = 5;
  localparam int unsigned F_RXF   = 6;
  localparam int unsigned F_RXOV  = 7;

  typedef enum logic [1:0] {
    CFG_MASK  = 2'd0,
    CFG_TXTHR = 2'd1,
    CFG_RXTHR = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fifo_irq_q.sv
module fifo_irq_q #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          hold_i,
  input  logic          push_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~hold_i & ~full;
  assign do_pop  = pop_i & ~hold_i & ~empty;
  assign ovf_o   = push_i & ~hold_i & full;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/fifo_irq_flush.sv
module fifo_irq_flush #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clear_o,
  output logic busy_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // A request while already busy is dropped
  assign clear_o = req_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/fifo_irq_stat.sv
module fifo_irq_stat
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    tx_cnt_i,
  input  logic [CW-1:0]    rx_cnt_i,
  input  logic [CW-1:0]    tx_thr_i,
  input  logic [CW-1:0]    rx_thr_i,
  input  logic             tx_ovf_i,
  input  logic             rx_ovf_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] mask_i,
  output logic [NFLAG-1:0] raw_o,
  output logic [NFLAG-1:0] masked_o,
  output logic             irq_o
);
  logic tx_ov_q, rx_ov_q, irq_q;

  // Set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ov_q <= 1'b0;
      rx_ov_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      tx_ov_q <= tx_ovf_i | (tx_ov_q & ~clr_i[F_TXOV]);
      rx_ov_q <= rx_ovf_i | (rx_ov_q & ~clr_i[F_RXOV]);
      irq_q   <= |masked_o;
    end
  end

  always_comb begin
    raw_o         = '0;
    raw_o[F_TXE]  = (tx_cnt_i == '0);
    raw_o[F_TXNE] = (tx_cnt_i <= tx_thr_i);
    raw_o[F_TXF]  = (tx_cnt_i == CW'(DEPTH));
    raw_o[F_TXOV] = tx_ov_q;
    raw_o[F_RXE]  = (rx_cnt_i == '0);
    raw_o[F_RXNF] = (rx_cnt_i >= rx_thr_i);
    raw_o[F_RXF]  = (rx_cnt_i == CW'(DEPTH));
    raw_o[F_RXOV] = rx_ov_q;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = irq_q;
endmodule

// File: rtl/fifo_irq_top.sv
module fifo_irq_top
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned FLUSH_CYCLES = 4,
  parameter int unsigned CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_rd_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  input  logic              rx_wr_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic [CNT_W-1:0]  tx_count_o,
  output logic [CNT_W-1:0]  rx_count_o,
  input  logic              tx_flush_i,
  input  logic              rx_flush_i,
  output logic              tx_flush_o,
  output logic              rx_flush_o,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [7:0]        clr_i,
  output logic [7:0]        raw_o,
  output logic [7:0]        masked_o,
  output logic              irq_o
);
  logic [NFLAG-1:0] mask_q;
  logic [CNT_W-1:0] tx_thr_q, rx_thr_q;
  logic             tx_clr, rx_clr, tx_ovf, rx_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        CFG_MASK:  mask_q   <= cfg_wdata_i;
        CFG_TXTHR: tx_thr_q <= cfg_wdata_i[CNT_W-1:0];
        CFG_RXTHR: rx_thr_q <= cfg_wdata_i[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

  fifo_irq_flush #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
    .clk_i, .rst_ni, .req_i(tx_flush_i), .clear_o(tx_clr), .busy_o(tx_flush_o)
  );
  fifo_irq_flush #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
    .clk_i, .rst_ni, .req_i(rx_flush_i), .clear_o(rx_clr), .busy_o(rx_flush_o)
  );

  fifo_irq_q #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_tx_q (
    .clk_i, .rst_ni,
    .clear_i(tx_clr), .hold_i(tx_clr | tx_flush_o),
    .push_i(tx_wr_i), .pdata_i(tx_wdata_i), .pop_i(tx_rd_i),
    .head_o(tx_rdata_o), .count_o(tx_count_o), .ovf_o(tx_ovf)
  );
  fifo_irq_q #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_rx_q (
    .clk_i, .rst_ni,
    .clear_i(rx_clr), .hold_i(rx_clr | rx_flush_o),
    .push_i(rx_wr_i), .pdata_i(rx_wdata_i), .pop_i(rx_rd_i),
    .head_o(rx_rdata_o), .count_o(rx_count_o), .ovf_o(rx_ovf)
  );

  fifo_irq_stat #(.DEPTH(DEPTH), .CW(CNT_W)) u_stat (
    .clk_i, .rst_ni,
    .tx_cnt_i(tx_count_o), .rx_cnt_i(rx_count_o),
    .tx_thr_i(tx_thr_q), .rx_thr_i(rx_thr_q),
    .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf),
    .clr_i, .mask_i(mask_q),
    .raw_o, .masked_o, .irq_o
  );
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_wr_i,
  input logic             tx_rd_i,
  input logic             rx_wr_i,
  input logic             tx_flush_i,
  input logic [CNT_W-1:0] tx_count_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic             tx_flush_o,
  input logic             rx_flush_o,
  input logic [7:0]       clr_i,
  input logic [7:0]       raw_o,
  input logic [7:0]       masked_o,
  input logic             irq_o
);
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count_o <= CNT_W'(DEPTH) && rx_count_o <= CNT_W'(DEPTH));

  a_r2_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_o == '0 && !tx_wr_i && !tx_flush_i) |=> tx_count_o == '0);

  a_r3_tx_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[3] && !clr_i[3]) |=> raw_o[3]);

  a_r3_rx_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[7] && !clr_i[7]) |=> raw_o[7]);

  a_r3_full_push_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_o == CNT_W'(DEPTH) && tx_wr_i && !tx_rd_i && !tx_flush_o && !tx_flush_i)
      |=> (tx_count_o == CNT_W'(DEPTH) && raw_o[3]));

  a_r7_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|masked_o) |=> irq_o);

  a_r7_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|masked_o) |=> !irq_o);

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_flush_o) |-> tx_count_o == '0);

  a_r9_tx_busy_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |-> tx_count_o == '0);

  a_r9_rx_busy_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |-> (rx_count_o == '0 && !(rx_wr_i && $rose(raw_o[7]))));
endmodule

bind fifo_irq_top fifo_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tx_wr_i, .tx_rd_i, .rx_wr_i, .tx_flush_i,
  .tx_count_o, .rx_count_o, .tx_flush_o, .rx_flush_o,
  .clr_i, .raw_o, .masked_o, .irq_o
);

// File: tb/fifo_irq_top_tb_top.sv
`timescale 1ns/1ps
module fifo_irq_top_tb_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned FC    = 4;
  localparam int unsigned CW    = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_wr_i = 0, tx_rd_i = 0, rx_wr_i = 0, rx_rd_i = 0;
  logic [7:0] tx_wdata_i = 0, rx_wdata_i = 0;
  logic [7:0] tx_rdata_o, rx_rdata_o;
  logic [CW-1:0] tx_count_o, rx_count_o;
  logic tx_flush_i = 0, rx_flush_i = 0, tx_flush_o, rx_flush_o;
  logic cfg_we_i = 0;
  logic [1:0] cfg_sel_i = 0;
  logic [7:0] cfg_wdata_i = 0, clr_i = 0, raw_o, masked_o;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fifo_irq_top dut_i (.*);

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] d;
    logic [4:0] cnt;
    logic [3:0] fl;
    logic [7:0] head;
  } vec_t;

  // tx threshold 2; fl = {ovr, full, nearly_empty, empty}
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 8'hA1, 5'd1, 4'b0010, 8'hA1},
    '{1'b1, 1'b0, 8'hB2, 5'd2, 4'b0010, 8'hA1},
    '{1'b1, 1'b0, 8'hC3, 5'd3, 4'b0000, 8'hA1},
    '{1'b0, 1'b1, 8'h00, 5'd2, 4'b0010, 8'hB2},
    '{1'b1, 1'b1, 8'hD4, 5'd2, 4'b0010, 8'hC3},
    '{1'b0, 1'b1, 8'h00, 5'd1, 4'b0010, 8'hD4},
    '{1'b0, 1'b1, 8'h00, 5'd0, 4'b0011, 8'h00},
    '{1'b0, 1'b1, 8'h00, 5'd0, 4'b0011, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] val);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = val;
    tick();
    cfg_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 tx_count", 32'(tx_count_o), 0);
    chk("R1 rx_count", 32'(rx_count_o), 0);
    chk("R1 raw", 32'(raw_o), 32'h33);
    chk("R1 masked", 32'(masked_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 busy", 32'({tx_flush_o, rx_flush_o}), 0);

    // R11 tx threshold 2, then vector table (R2 R4 R5)
    cfg(2'd1, 8'd2);
    chk("R11 tx thr applied", 32'(raw_o[1]), 1);
    foreach (VEC[i]) begin
      tx_wr_i = VEC[i].wr; tx_rd_i = VEC[i].rd; tx_wdata_i = VEC[i].d;
      tick();
      chk("R2 count", 32'(tx_count_o), 32'(VEC[i].cnt));
      chk("R5 R4 tx flags", 32'(raw_o[3:0]), 32'(VEC[i].fl));
      if (VEC[i].cnt != 0) chk("R2 head", 32'(tx_rdata_o), 32'(VEC[i].head));
    end
    tx_wr_i = 0; tx_rd_i = 0;

    // fill to full
    for (int i = 0; i < DEPTH; i++) begin
      tx_wr_i = 1; tx_wdata_i = 8'(8'h10 + i);
      tick();
    end
    chk("R4 tx full", 32'(raw_o[2:0]), 32'b100);
    chk("R4 tx count full", 32'(tx_count_o), DEPTH);
    // R3 overrun with simultaneous pop: push still dropped
    tx_wdata_i = 8'hEE; tx_rd_i = 1;
    tick();
    tx_rd_i = 0;
    chk("R3 overrun set", 32'(raw_o[3]), 1);
    chk("R3 count after pop", 32'(tx_count_o), DEPTH - 1);
    tx_wdata_i = 8'hEF;
    tick();
    chk("R2 refill to full", 32'(tx_count_o), DEPTH);
    tx_wdata_i = 8'hEE;
    tick();
    tx_wr_i = 0;
    chk("R3 dropped count", 32'(tx_count_o), DEPTH);
    chk("R7 irq masked off", 32'(irq_o), 0);
    cfg(2'd0, 8'h08);
    chk("R7 masked", 32'(masked_o), 32'h08);
    chk("R7 irq lag", 32'(irq_o), 0);
    tick();
    chk("R7 irq set", 32'(irq_o), 1);
    clr_i = 8'h77;
    tick();
    clr_i = 0;
    chk("R10 non-sticky clear", 32'(raw_o), 32'h0C | 32'h30 | 32'h00);
    tx_wr_i = 1; clr_i = 8'h08;
    tick();
    tx_wr_i = 0; clr_i = 0;
    chk("R3 set beats clear", 32'(raw_o[3]), 1);
    clr_i = 8'h08;
    tick();
    clr_i = 0;
    chk("R3 cleared", 32'(raw_o[3]), 0);
    tick();
    chk("R7 irq drop", 32'(irq_o), 0);
    chk("R3 content kept", 32'(tx_rdata_o), 32'h11);
    tx_rd_i = 1;
    tick();
    tx_rd_i = 0;
    chk("R2 next head", 32'(tx_rdata_o), 32'h12);

    // R8 R9 flush
    tx_flush_i = 1;
    tick();
    tx_flush_i = 0;
    chk("R8 busy", 32'(tx_flush_o), 1);
    chk("R8 emptied", 32'(tx_count_o), 0);
    tx_wr_i = 1; tx_wdata_i = 8'h55; tx_flush_i = 1;
    for (int k = 1; k < FC; k++) begin
      tick();
      tx_flush_i = 0;
      chk("R8 busy held", 32'(tx_flush_o), 1);
      chk("R9 push ignored", 32'(tx_count_o), 0);
    end
    tick();
    tx_wr_i = 0;
    chk("R8 self clear", 32'(tx_flush_o), 0);
    chk("R9 last push ignored", 32'(tx_count_o), 0);
    chk("R9 no overrun", 32'(raw_o[3]), 0);
    for (int i = 0; i < 3; i++) begin
      tx_wr_i = 1; tx_wdata_i = 8'(i);
      tick();
    end
    tx_wr_i = 0;
    chk("R8 thr kept", 32'(raw_o[1:0]), 0);
    chk("R8 mask kept", 32'(masked_o), 0);

    // RX side: R6 R4 R3
    cfg(2'd2, 8'd3);
    chk("R6 thr 3 empty", 32'(raw_o[5:4]), 32'b01);
    for (int i = 0; i < 3; i++) begin
      rx_wr_i = 1; rx_wdata_i = 8'(8'h40 + i);
      tick();
      chk("R6 nearly full", 32'(raw_o[5]), (i == 2) ? 1 : 0);
    end
    rx_wr_i = 0;
    chk("R2 rx head", 32'(rx_rdata_o), 32'h40);
    rx_rd_i = 1;
    tick();
    rx_rd_i = 0;
    chk("R6 drop below", 32'(raw_o[5]), 0);
    for (int i = 0; i < DEPTH - 2; i++) begin
      rx_wr_i = 1; rx_wdata_i = 8'(i);
      tick();
    end
    chk("R4 rx full", 32'(raw_o[6]), 1);
    tick();
    rx_wr_i = 0;
    chk("R3 rx overrun", 32'(raw_o[7]), 1);
    rx_rd_i = 1;
    tick();
    rx_rd_i = 0;
    chk("R4 rx full clears", 32'(raw_o[6]), 0);
    chk("R2 rx count", 32'(rx_count_o), DEPTH - 1);
    cfg(2'd3, 8'hFF);
    chk("R11 sel 3 no write", 32'(masked_o), 0);
    cfg(2'd0, 8'hFF);
    chk("R7 full mask", 32'(masked_o), 32'(raw_o));
    rx_flush_i = 1;
    tick();
    rx_flush_i = 0;
    chk("R8 rx flush", 32'({rx_flush_o, rx_count_o}), 32'({1'b1, 5'd0}));
    chk("R4 rx empty", 32'(raw_o[4]), 1);
    repeat (FC) tick();
    chk("R8 rx self clear", 32'(rx_flush_o), 0);
    chk("R3 rx sticky after flush", 32'(raw_o[7]), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule